// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a digital model of a clock-synchronous voltage-to-frequency modulator. A signed input level gives the input as a fraction of a reference, with 4096 as full scale. On selected rising edges of the master clock the block emits one pulse, and the long-term pulse rate follows an offset linear law. A zero level gives one tenth of the clock rate. Full scale gives nine tenths. A first-order accumulator does the work of the integrator. When it wraps past its modulus, the wrap takes the place of the comparator and the one-bit feedback.

Pulses are not evenly spaced. The accumulator spreads them so that the average is exact over any long window, and each pulse fills the high phase of the clock cycle it belongs to. A second, free-running timebase clock watches the master clock. If the master clock stays low for a set number of timebase ticks, the block drops into power-down. It then drives its output high and holds its state. The first master-clock edge after that restarts the accumulator from zero.

Top module: `cb_pulse_mod`

## Requirements
- R1: While reset is asserted and after it is released, pulse_out is low and the accumulator is zero. With level 0 the first pulse appears after the tenth master-clock rising edge following reset release.
- R2: Each master-clock cycle adds the increment FS + 8·L to the accumulator, where L is the clamped level and FS = 4096. The modulus is 10·FS = 40960. Over N cycles the pulse count is within ±1 of floor(N·(FS + 8·L)/(10·FS)).
- R3: The accumulator always stays below the modulus. A pulse is scheduled exactly when the sum reaches the modulus, and the modulus is then subtracted.
- R4: pulse_out can be high only during the high phase of the master clock that follows the edge that scheduled the pulse. It is low in every low phase while the block is not powered down.
- R5: The level is clamped to the range -245 to 4341, about 6 % of span on each side. Levels beyond that range give the same rate as the nearest limit.
- R6: With level 1024 (rate 3/10), successive pulses are always 3 or 4 clock cycles apart.
- R7: While the rate is at most half the clock (level at most 2048), two pulses never fall on consecutive cycles.
- R8: When the master clock stays low for IDLE_TICKS timebase ticks after its synchronizer, the block enters power-down and pulse_out is held high.
- R9: A low stretch of the master clock shorter than the power-down limit leaves pulse_out low.
- R10: On the first master-clock rising edge seen while powered down, the accumulator is cleared and no pulse is scheduled. pulse_out drops, and pulses then resume on the schedule that starts from zero.
- R11: A change of level takes effect on the next master-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; sets the pulse timing |
| tick_clk | input | 1 | Free-running timebase clock for the inactivity detector |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| level | input | CODE_W (14) | Signed input level, full scale 4096 |
| pulse_out | output | 1 | Pulse train; held high in power-down |

## Verification
Power-down exit and the accumulator update can fall on the same master-clock edge. That first edge must both clear the accumulator and begin normal operation. The bench runs at full scale, stops the clock low long enough to trip the detector, confirms the output is held high, then restarts the clock. It judges the result by the pulse pattern in the high phases: two empty phases followed by a pulse, which is only possible if the accumulator restarted from zero. A shorter stop is also run. The output must stay low there, which separates the detector threshold from the wake path.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    // overrange allowance on each side, percent of span
    localparam int OVR_PCT = 6;
    // rate law: rate = (FS + GAIN_NUM*L) / (MOD_MUL*FS)
    localparam int GAIN_NUM = 8;
    localparam int MOD_MUL  = 10;

    typedef enum logic {
        IDLE_RUN  = 1'b0,
        IDLE_DOWN = 1'b1
    } idle_st_e;

endpackage

// File: rtl/cbm_scale.sv
module cbm_scale #(
    parameter int FS_W   = 12,
    parameter int CODE_W = 14,
    parameter int INC_W  = 16
) (
    input  logic signed [CODE_W-1:0] level_i,
    output logic        [INC_W-1:0]  inc_o
);
    import cbm_pkg::*;

    localparam int FS     = 1 << FS_W;
    localparam int OVR    = (FS * OVR_PCT) / 100;
    localparam int LVL_LO = -OVR;
    localparam int LVL_HI = FS + OVR;

    int lvl_ext;
    int lvl_clamped;
    int inc_full;

    always_comb begin
        lvl_ext = int'(level_i);
        if (lvl_ext < LVL_LO) begin
            lvl_clamped = LVL_LO;
        end else if (lvl_ext > LVL_HI) begin
            lvl_clamped = LVL_HI;
        end else begin
            lvl_clamped = lvl_ext;
        end
        inc_full = FS + GAIN_NUM * lvl_clamped;
        inc_o    = INC_W'(inc_full);
    end

endmodule

// File: rtl/cbm_accum.sv
module cbm_accum #(
    parameter int MOD   = 40960,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             pd_i,
    output logic             fire_o,
    output logic             woke_o
);
    localparam logic [ACC_W:0]   MOD_W  = (ACC_W+1)'(MOD);
    localparam logic [ACC_W-1:0] HALF_W = ACC_W'(MOD / 2);
    localparam logic [ACC_W-1:0] INC_LO = ACC_W'(MOD / 20);
    localparam logic [ACC_W-1:0] INC_HI = ACC_W'(MOD - MOD / 20);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             fire;
        logic             woke;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + {1'b0, inc_i};
        if (pd_i && !st_q.woke) begin
            st_d.acc  = '0;
            st_d.fire = 1'b0;
        end else if (sum_d >= MOD_W) begin
            st_d.acc  = ACC_W'(sum_d - MOD_W);
            st_d.fire = 1'b1;
        end else begin
            st_d.acc  = sum_d[ACC_W-1:0];
            st_d.fire = 1'b0;
        end
        st_d.woke = pd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = st_q.fire;
    assign woke_o = st_q.woke;

    // R3: charge stays bounded below the modulus
    a_r3_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.acc} < MOD_W);

    // R5: clamped increment stays inside the overrange window
    a_r5_inc_window: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i >= INC_LO) && (inc_i <= INC_HI));

    // R7: two back-to-back pulses need an increment of at least half the modulus
    a_r7_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fire && $past(st_q.fire) && !$past(pd_i)) |->
            (($past(inc_i) >= HALF_W) || ($past(inc_i, 2) >= HALF_W)));

    // R10: first edge in power-down clears the loop
    a_r10_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_i && !st_q.woke) |=> (st_q.acc == '0) && !st_q.fire);

endmodule

// File: rtl/cbm_idle.sv
module cbm_idle #(
    parameter int IDLE_TICKS = 1000
) (
    input  logic tick_clk,
    input  logic rst_n,
    input  logic clk_level_i,
    output logic pd_o
);
    import cbm_pkg::*;

    localparam int CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_TICKS - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [CNT_W-1:0] cnt;
        idle_st_e         st;
    } idle_t;

    idle_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = clk_level_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.cnt = '0;
            st_d.st  = IDLE_RUN;
        end else if (st_q.cnt == LAST) begin
            st_d.st  = IDLE_DOWN;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge tick_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b0, s2: 1'b0, cnt: '0, st: IDLE_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_o = (st_q.st == IDLE_DOWN);

    // R8: power-down only starts while the sampled clock is low
    a_r8_enter_low: assert property (@(posedge tick_clk) disable iff (!rst_n)
        $rose(pd_o) |-> !st_q.s2);

    // R8: counter never passes its terminal value
    a_r8_cnt_limit: assert property (@(posedge tick_clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R10: activity seen on the clock ends power-down next tick
    a_r10_leave_on_high: assert property (@(posedge tick_clk) disable iff (!rst_n)
        st_q.s2 |=> !pd_o);

endmodule

// File: rtl/cb_pulse_mod.sv
module cb_pulse_mod #(
    parameter int FS_W       = 12,
    parameter int CODE_W     = FS_W + 2,
    parameter int IDLE_TICKS = 1000
) (
    input  logic                     clk,
    input  logic                     tick_clk,
    input  logic                     rst_n,
    input  logic signed [CODE_W-1:0] level,
    output logic                     pulse_out
);
    import cbm_pkg::*;

    localparam int FS    = 1 << FS_W;
    localparam int MOD   = MOD_MUL * FS;
    localparam int ACC_W = $clog2(MOD);

    logic [ACC_W-1:0] inc;
    logic             fire;
    logic             woke;
    logic             pd;

    cbm_scale #(
        .FS_W   (FS_W),
        .CODE_W (CODE_W),
        .INC_W  (ACC_W)
    ) scale_i (
        .level_i (level),
        .inc_o   (inc)
    );

    cbm_accum #(
        .MOD   (MOD),
        .ACC_W (ACC_W)
    ) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc),
        .pd_i   (pd),
        .fire_o (fire),
        .woke_o (woke)
    );

    cbm_idle #(
        .IDLE_TICKS (IDLE_TICKS)
    ) idle_i (
        .tick_clk    (tick_clk),
        .rst_n       (rst_n),
        .clk_level_i (clk),
        .pd_o        (pd)
    );

    // pulse fills the clock-high phase; power-down forces the line high
    assign pulse_out = (pd & ~woke) | (fire & clk);

    // R1/R4: no stray pulse straight out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fire);

endmodule

// File: tb/cb_pulse_mod_tb.sv
module cb_pulse_mod_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int TICK_HALF  = 4;
    localparam int IDLE_T     = 20;
    localparam int NCYC       = 10000;
    localparam int NVEC       = 9;

    localparam int VEC_CODE [NVEC] = '{0, 4096, 1024, 2048, 100, -245, 4341, -3000, 7000};
    localparam int VEC_EXP  [NVEC] = '{1000, 9000, 3000, 5000, 1195, 521, 9478, 521, 9478};

    logic              clk = 1'b0;
    logic              tick_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [13:0] level = '0;
    logic              pulse_out;
    logic              clk_run = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    cb_pulse_mod #(
        .FS_W       (12),
        .CODE_W     (14),
        .IDLE_TICKS (IDLE_T)
    ) dut_i (
        .clk       (clk),
        .tick_clk  (tick_clk),
        .rst_n     (rst_n),
        .level     (level),
        .pulse_out (pulse_out)
    );

    initial begin
        forever begin
            if (clk_run) begin
                #HALF clk = 1'b1;
                #HALF clk = 1'b0;
            end else begin
                #1;
            end
        end
    end

    initial forever #TICK_HALF tick_clk = ~tick_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int hi_cnt;
        int lo_bad;
        int adj_bad;
        int gap_bad;
        int last_idx;
        bit prev_hi;
        bit low_rate;
        bit seen_bad;

        // R1: reset state
        level = '0;
        repeat (3) @(posedge clk);
        #2;
        check(pulse_out == 1'b0, "R1 reset output", int'(pulse_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R3: with level 0 the first pulse lands on edge 10
        seen_bad = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk);
            #2;
            if (k < 10 && pulse_out) seen_bad = 1;
            if (k == 10) check(pulse_out == 1'b1, "R1 first pulse edge 10", int'(pulse_out), 1);
        end
        check(!seen_bad, "R3 no early pulse after reset", int'(seen_bad), 0);

        // R2/R5/R6/R7/R4/R11: table of levels and expected counts
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk);
            #7;
            level = 14'(VEC_CODE[v]);
            low_rate = (VEC_CODE[v] <= 2048);
            hi_cnt = 0; lo_bad = 0; adj_bad = 0; gap_bad = 0;
            last_idx = -1; prev_hi = 0;
            for (int c = 0; c < NCYC; c++) begin
                @(posedge clk);
                #2;
                if (pulse_out) begin
                    hi_cnt++;
                    if (prev_hi) adj_bad++;
                    if (last_idx >= 0 && (c - last_idx) != 3 && (c - last_idx) != 4) gap_bad++;
                    last_idx = c;
                end
                prev_hi = pulse_out;
                #5;
                if (pulse_out) lo_bad++;
            end
            check((hi_cnt >= VEC_EXP[v] - 1) && (hi_cnt <= VEC_EXP[v] + 1),
                  (VEC_CODE[v] < -245 || VEC_CODE[v] > 4341) ? "R5 clamped rate" : "R2 R11 rate",
                  hi_cnt, VEC_EXP[v]);
            check(lo_bad == 0, "R4 low phase quiet", lo_bad, 0);
            if (low_rate) check(adj_bad == 0, "R7 no adjacent pulses", adj_bad, 0);
            if (VEC_CODE[v] == 1024) check(gap_bad == 0, "R6 gap 3 or 4", gap_bad, 0);
        end

        // R9: short low stretch does not power down
        level = 14'sd4096;
        repeat (5) @(posedge clk);
        #2;
        clk_run = 1'b0;
        #80;
        check(pulse_out == 1'b0, "R9 short stop stays low", int'(pulse_out), 0);
        clk_run = 1'b1;
        repeat (20) @(posedge clk);

        // R8: long low stretch forces the output high
        #2;
        clk_run = 1'b0;
        #400;
        check(pulse_out == 1'b1, "R8 power-down output high", int'(pulse_out), 1);
        #100;
        check(pulse_out == 1'b1, "R8 power-down held", int'(pulse_out), 1);

        // R10: wake clears the loop; full-scale schedule restarts from zero
        clk_run = 1'b1;
        @(posedge clk);
        #2;
        check(pulse_out == 1'b0, "R10 wake edge 1 no pulse", int'(pulse_out), 0);
        @(posedge clk);
        #2;
        check(pulse_out == 1'b0, "R10 wake edge 2 no pulse", int'(pulse_out), 0);
        @(posedge clk);
        #2;
        check(pulse_out == 1'b1, "R10 wake edge 3 pulse", int'(pulse_out), 1);
        @(posedge clk);
        #2;
        check(pulse_out == 1'b1, "R10 wake edge 4 pulse", int'(pulse_out), 1);
        #5;
        check(pulse_out == 1'b0, "R4 low phase after wake", int'(pulse_out), 0);

        finish_run();
    end

endmodule